// File: doc/BRIEF.md
# Segment LCD Command Byte Decoder

This block interprets the byte stream that a byte-level I2C target receiver delivers for a multiplexed segment LCD driver. The receiver reports START and STOP conditions and each completed byte. For each byte, the decoder returns in the same cycle whether the byte should be acknowledged. The first byte after a START or STOP is treated as the address byte. When it matches and requests a write, the bytes that follow are parsed as commands. Each command byte carries a flag in its most significant bit that says whether another command follows. Once a command arrives with that flag clear, every later byte is display data.

The decoder holds the display configuration: drive mode, bias, display enable, write bank, shown bank, blink style and blink rate. It also holds the RAM column pointer and the subaddress counter. Each display data byte advances the column pointer by a step that depends on the drive mode. When the pointer passes the last column it wraps, and the subaddress counter increments. A data byte is acknowledged and handed to the display-data path only when the subaddress counter equals the strapped hardware subaddress. The pointer advances in either case, so several cascaded devices stay in step.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: The address byte is acknowledged only when bits 7:1 equal 0111 00s, where s is the `addr_sel_i` level, and bit 0 (read/write) is 0. Any other address byte is not acknowledged, and every byte after it is neither acknowledged nor acted on until the next START or STOP.
- R2: After a matching address, every command byte is acknowledged. When bit 7 of a command byte is 1, the next byte is parsed as a command. When bit 7 is 0, all following bytes are display data.
- R3: A command with bits 6:5 = 10 sets the configuration fields, which appear on the outputs from the next cycle. Bit 3 sets display enable. Bit 2 sets bias (0 = one-third, 1 = one-half). Bits 1:0 set the drive mode (01 static, 10 two-way, 11 three-way, 00 four-way multiplex).
- R4: A command with bits 6:5 = 00 loads bits 4:0 into the column pointer.
- R5: A command with bits 6:3 = 1100 loads bits 2:0 into the subaddress counter.
- R6: A command with bits 6:2 = 11110 sets the write bank from bit 1 and the shown bank from bit 0.
- R7: A command with bits 6:3 = 1110 sets the alternate-bank blink flag from bit 2 and the blink rate from bits 1:0.
- R8: A command byte that matches none of these patterns changes no configuration. It is still acknowledged, and its bit 7 still decides whether the next byte is a command or data.
- R9: A data byte is acknowledged only when the subaddress counter equals `hw_subaddr_i`. In that case, on the next cycle `data_valid_o` pulses for one cycle, with the byte on `data_o` and the pre-advance column on `wr_col_o`.
- R10: Every data byte advances the column pointer, whether or not it is acknowledged: by 8 in static, 4 in two-way, 3 in three-way and 2 in four-way mode. A result past column 31 wraps modulo 32 and increments the subaddress counter.
- R11: After reset, the display is disabled, the bias is one-third, the mode is four-way, both banks are 0, the blink fields are 0, and the pointer and subaddress counter are 0.
- R12: A START or STOP returns the parser to the address-byte state. A byte strobe in the same cycle as a START or STOP is ignored and is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | START or repeated START seen |
| stop_i | input | 1 | STOP seen |
| byte_valid_i | input | 1 | A received byte is on byte_i |
| byte_i | input | 8 | Received byte |
| addr_sel_i | input | 1 | Strapped address select bit |
| hw_subaddr_i | input | 3 | Strapped hardware subaddress |
| ack_o | output | 1 | Acknowledge the current byte (same cycle) |
| disp_en_o | output | 1 | Display enable |
| bias_half_o | output | 1 | 1 = one-half bias, 0 = one-third |
| mode_o | output | 2 | Drive mode code |
| in_bank_o | output | 1 | Bank that receives data |
| out_bank_o | output | 1 | Bank that is shown |
| blink_alt_o | output | 1 | Blink by alternating banks |
| blink_freq_o | output | 2 | Blink rate code |
| data_ptr_o | output | 5 | Current column pointer |
| subaddr_o | output | 3 | Subaddress counter |
| data_valid_o | output | 1 | Display data write strobe |
| data_o | output | 8 | Display data byte |
| wr_col_o | output | 5 | Column for the data byte |

## Verification
Two functions can fall in the same cycle. The first is the pointer wrap that increments the subaddress counter. The second is the acknowledge decision for that same data byte, which must use the counter value from before the increment. The bench provokes this by loading column 30 in static and three-way modes and then sending two data bytes. It expects the first byte to be acknowledged, written at column 30 and followed by a counter step, and the second byte to go unacknowledged. A START strobe presented in the same cycle as a byte is also provoked, and the bench expects no acknowledge and no change of state.

// File: rtl/lcd_cmd_pkg.sv
// Shared types and helpers for the segment LCD command decoder.
// Assumes a drive-mode code of 2 bits and column steps of at most 8.
package lcd_cmd_pkg;

    typedef enum logic [1:0] {
        PS_ADDR = 2'd0,
        PS_CMD  = 2'd1,
        PS_DATA = 2'd2,
        PS_SKIP = 2'd3
    } parse_state_t;

    typedef enum logic [1:0] {
        MUX_FOUR   = 2'b00,
        MUX_STATIC = 2'b01,
        MUX_TWO    = 2'b10,
        MUX_THREE  = 2'b11
    } drive_mode_t;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_MODE  = 3'd1,
        OP_PTR   = 3'd2,
        OP_DEV   = 3'd3,
        OP_BANK  = 3'd4,
        OP_BLINK = 3'd5
    } opcode_t;

    typedef struct packed {
        logic        disp_en;
        logic        bias_half;
        drive_mode_t mode;
        logic        in_bank;
        logic        out_bank;
        logic        blink_alt;
        logic [1:0]  blink_freq;
    } disp_cfg_t;

    // Columns consumed by one data byte in each drive mode.
    function automatic logic [3:0] col_step(input drive_mode_t m);
        case (m)
            MUX_STATIC: col_step = 4'd8;
            MUX_TWO:    col_step = 4'd4;
            MUX_THREE:  col_step = 4'd3;
            default:    col_step = 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/lcd_addr_match.sv
// Address byte comparator. Flags a write request to this device.
// Assumes a 7-bit address whose low bit comes from a strap input.
module lcd_addr_match #(
    parameter logic [5:0] ADDR_HI = 6'b011100
) (
    input  logic [7:0] byte_i,
    input  logic       sel_i,
    output logic       hit_o
);
    // Match the upper six bits, the strap bit and a write direction.
    always_comb begin
        hit_o = (byte_i[7:2] == ADDR_HI) && (byte_i[1] == sel_i) && !byte_i[0];
    end
endmodule

// File: rtl/lcd_op_decode.sv
// Command byte classifier. Pure combinational decode of the opcode
// pattern in bits 6:0, plus the continuation flag in bit 7.
module lcd_op_decode
    import lcd_cmd_pkg::*;
(
    input  logic [7:0] byte_i,
    output opcode_t    op_o,
    output logic       cont_o
);
    // Sort the byte into one opcode; unmatched patterns give OP_NONE.
    always_comb begin
        cont_o = byte_i[7];
        if (byte_i[6:5] == 2'b10)
            op_o = OP_MODE;
        else if (byte_i[6:5] == 2'b00)
            op_o = OP_PTR;
        else if (byte_i[6:3] == 4'b1100)
            op_o = OP_DEV;
        else if (byte_i[6:2] == 5'b11110)
            op_o = OP_BANK;
        else if (byte_i[6:3] == 4'b1110)
            op_o = OP_BLINK;
        else
            op_o = OP_NONE;
    end
endmodule

// File: rtl/lcd_cfg_regs.sv
// Display configuration register set. Each write strobe updates the
// fields carried by one command kind. Synchronous active-low reset.
module lcd_cfg_regs
    import lcd_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_mode_i,
    input  logic       wr_bank_i,
    input  logic       wr_blink_i,
    input  logic [7:0] byte_i,
    output disp_cfg_t  cfg_o
);
    disp_cfg_t cfg_q;

    // Hold the configuration and apply the field updates of one command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{disp_en: 1'b0, bias_half: 1'b0, mode: MUX_FOUR,
                       in_bank: 1'b0, out_bank: 1'b0, blink_alt: 1'b0,
                       blink_freq: 2'b00};
        end else begin
            if (wr_mode_i) begin
                cfg_q.disp_en   <= byte_i[3];
                cfg_q.bias_half <= byte_i[2];
                cfg_q.mode      <= drive_mode_t'(byte_i[1:0]);
            end
            if (wr_bank_i) begin
                cfg_q.in_bank  <= byte_i[1];
                cfg_q.out_bank <= byte_i[0];
            end
            if (wr_blink_i) begin
                cfg_q.blink_alt  <= byte_i[2];
                cfg_q.blink_freq <= byte_i[1:0];
            end
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/lcd_col_ctrl.sv
// Column pointer and subaddress counter. Loads come from commands.
// An advance adds the mode step, wraps past the last column and then
// bumps the subaddress. Assumes load and advance never coincide.
module lcd_col_ctrl
    import lcd_cmd_pkg::*;
#(
    parameter int COLS  = 32,
    parameter int SUB_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_ptr_i,
    input  logic [$clog2(COLS)-1:0]  ptr_val_i,
    input  logic                     load_sub_i,
    input  logic [SUB_W-1:0]         sub_val_i,
    input  logic                     advance_i,
    input  drive_mode_t              mode_i,
    output logic [$clog2(COLS)-1:0]  ptr_o,
    output logic [SUB_W-1:0]         sub_o
);
    localparam int PTR_W = $clog2(COLS);
    localparam int SUM_W = PTR_W + 4;

    logic [PTR_W-1:0] ptr_q;
    logic [SUB_W-1:0] sub_q;
    logic [SUM_W-1:0] sum;
    logic             wrap;

    // Next column before wrap, and whether it runs past the last column.
    always_comb begin
        sum  = SUM_W'(ptr_q) + SUM_W'(col_step(mode_i));
        wrap = (sum >= SUM_W'(COLS));
    end

    // Pointer register: load from a command or advance after a data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (load_ptr_i)
            ptr_q <= ptr_val_i;
        else if (advance_i)
            ptr_q <= wrap ? PTR_W'(sum - SUM_W'(COLS)) : PTR_W'(sum);
    end

    // Subaddress counter: load from a command or step on pointer wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub_q <= '0;
        else if (load_sub_i)
            sub_q <= sub_val_i;
        else if (advance_i && wrap)
            sub_q <= sub_q + 1'b1;
    end

    assign ptr_o = ptr_q;
    assign sub_o = sub_q;
endmodule

// File: rtl/lcd_cmd_decoder.sv
// Top of the command byte decoder. It tracks the position within a
// transfer (address, command chain, data, ignored), decides the
// acknowledge for each byte in the same cycle, routes commands to the
// configuration and pointer logic, and issues display data writes.
// Assumes start/stop/byte strobes are single-cycle and synchronous.
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b011100,
    parameter int         COLS    = 32,
    parameter int         SUB_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    stop_i,
    input  logic                    byte_valid_i,
    input  logic [7:0]              byte_i,
    input  logic                    addr_sel_i,
    input  logic [SUB_W-1:0]        hw_subaddr_i,
    output logic                    ack_o,
    output logic                    disp_en_o,
    output logic                    bias_half_o,
    output logic [1:0]              mode_o,
    output logic                    in_bank_o,
    output logic                    out_bank_o,
    output logic                    blink_alt_o,
    output logic [1:0]              blink_freq_o,
    output logic [$clog2(COLS)-1:0] data_ptr_o,
    output logic [SUB_W-1:0]        subaddr_o,
    output logic                    data_valid_o,
    output logic [7:0]              data_o,
    output logic [$clog2(COLS)-1:0] wr_col_o
);
    localparam int PTR_W = $clog2(COLS);

    parse_state_t     state_q;
    logic             byte_ok;
    logic             addr_hit;
    opcode_t          op;
    logic             cont;
    logic             sub_match;
    logic             cmd_fire;
    logic             data_fire;
    disp_cfg_t        cfg;
    logic [PTR_W-1:0] ptr;
    logic [SUB_W-1:0] sub;

    lcd_addr_match #(.ADDR_HI(ADDR_HI)) u_addr (
        .byte_i (byte_i),
        .sel_i  (addr_sel_i),
        .hit_o  (addr_hit)
    );

    lcd_op_decode u_dec (
        .byte_i (byte_i),
        .op_o   (op),
        .cont_o (cont)
    );

    // Qualify the byte strobe and classify it by parser position.
    always_comb begin
        byte_ok   = byte_valid_i && !start_i && !stop_i;
        sub_match = (sub == hw_subaddr_i);
        cmd_fire  = byte_ok && (state_q == PS_CMD);
        data_fire = byte_ok && (state_q == PS_DATA);
    end

    // Same-cycle acknowledge decision for the byte on byte_i.
    always_comb begin
        ack_o = 1'b0;
        if (byte_ok) begin
            case (state_q)
                PS_ADDR: ack_o = addr_hit;
                PS_CMD:  ack_o = 1'b1;
                PS_DATA: ack_o = sub_match;
                default: ack_o = 1'b0;
            endcase
        end
    end

    // Parser position: bus conditions restart it, bytes move it forward.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PS_ADDR;
        else if (start_i || stop_i)
            state_q <= PS_ADDR;
        else if (byte_ok) begin
            case (state_q)
                PS_ADDR: state_q <= addr_hit ? PS_CMD : PS_SKIP;
                PS_CMD:  state_q <= cont ? PS_CMD : PS_DATA;
                default: state_q <= state_q;
            endcase
        end
    end

    lcd_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mode_i  (cmd_fire && (op == OP_MODE)),
        .wr_bank_i  (cmd_fire && (op == OP_BANK)),
        .wr_blink_i (cmd_fire && (op == OP_BLINK)),
        .byte_i     (byte_i),
        .cfg_o      (cfg)
    );

    lcd_col_ctrl #(.COLS(COLS), .SUB_W(SUB_W)) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_ptr_i (cmd_fire && (op == OP_PTR)),
        .ptr_val_i  (byte_i[PTR_W-1:0]),
        .load_sub_i (cmd_fire && (op == OP_DEV)),
        .sub_val_i  (byte_i[SUB_W-1:0]),
        .advance_i  (data_fire),
        .mode_i     (cfg.mode),
        .ptr_o      (ptr),
        .sub_o      (sub)
    );

    // Display data handoff: one strobe per acknowledged data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_valid_o <= 1'b0;
            data_o       <= '0;
            wr_col_o     <= '0;
        end else begin
            data_valid_o <= data_fire && sub_match;
            if (data_fire && sub_match) begin
                data_o   <= byte_i;
                wr_col_o <= ptr;
            end
        end
    end

    assign disp_en_o    = cfg.disp_en;
    assign bias_half_o  = cfg.bias_half;
    assign mode_o       = cfg.mode;
    assign in_bank_o    = cfg.in_bank;
    assign out_bank_o   = cfg.out_bank;
    assign blink_alt_o  = cfg.blink_alt;
    assign blink_freq_o = cfg.blink_freq;
    assign data_ptr_o   = ptr;
    assign subaddr_o    = sub;
endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
// Port-level property checker for lcd_cmd_decoder, bound to every instance.
module lcd_cmd_decoder_chk #(
    parameter int PTR_W = 5,
    parameter int SUB_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic             byte_valid_i,
    input logic [7:0]       byte_i,
    input logic             ack_o,
    input logic             disp_en_o,
    input logic             bias_half_o,
    input logic [1:0]       mode_o,
    input logic             in_bank_o,
    input logic             out_bank_o,
    input logic             blink_alt_o,
    input logic [1:0]       blink_freq_o,
    input logic [PTR_W-1:0] data_ptr_o,
    input logic [SUB_W-1:0] subaddr_o,
    input logic             data_valid_o,
    input logic [7:0]       data_o
);
    // R12
    ack_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (byte_valid_i && !start_i && !stop_i));

    // R9
    dv_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> $past(ack_o));

    // R9
    dv_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> (data_o == $past(byte_i)));

    // R10
    sub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i |=> $stable(subaddr_o) && $stable(data_ptr_o));

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i |=> $stable({disp_en_o, bias_half_o, mode_o, in_bank_o,
                                   out_bank_o, blink_alt_o, blink_freq_o}));
endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk #(.PTR_W(PTR_W), .SUB_W(SUB_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .ack_o        (ack_o),
    .disp_en_o    (disp_en_o),
    .bias_half_o  (bias_half_o),
    .mode_o       (mode_o),
    .in_bank_o    (in_bank_o),
    .out_bank_o   (out_bank_o),
    .blink_alt_o  (blink_alt_o),
    .blink_freq_o (blink_freq_o),
    .data_ptr_o   (data_ptr_o),
    .subaddr_o    (subaddr_o),
    .data_valid_o (data_valid_o),
    .data_o       (data_o)
);

// File: tb/lcd_cmd_decoder_test.sv
module lcd_cmd_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       addr_sel_i = 1'b0;
    logic [2:0] hw_subaddr_i = 3'd0;
    logic       ack_o, disp_en_o, bias_half_o, in_bank_o, out_bank_o, blink_alt_o;
    logic [1:0] mode_o, blink_freq_o;
    logic [4:0] data_ptr_o, wr_col_o;
    logic [2:0] subaddr_o;
    logic       data_valid_o;
    logic [7:0] data_o;

    int n_run = 0;
    int n_fail = 0;

    // Bench model of the decoder state.
    int         m_st = 0;           // 0 addr, 1 cmd, 2 data, 3 ignore
    logic [8:0] m_cfg = 9'h000;     // {en,bias,mode[1:0],in,out,alt,freq[1:0]}
    logic [4:0] m_ptr = 5'd0;
    logic [2:0] m_sub = 3'd0;
    logic       m_dv = 1'b0;
    logic [7:0] m_data = 8'h00;
    logic [4:0] m_col = 5'd0;
    string      m_tag = "R1";

    always #5 clk = ~clk;

    lcd_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .addr_sel_i(addr_sel_i),
        .hw_subaddr_i(hw_subaddr_i), .ack_o(ack_o), .disp_en_o(disp_en_o),
        .bias_half_o(bias_half_o), .mode_o(mode_o), .in_bank_o(in_bank_o),
        .out_bank_o(out_bank_o), .blink_alt_o(blink_alt_o),
        .blink_freq_o(blink_freq_o), .data_ptr_o(data_ptr_o),
        .subaddr_o(subaddr_o), .data_valid_o(data_valid_o), .data_o(data_o),
        .wr_col_o(wr_col_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int step_of(input logic [1:0] m);
        case (m)
            2'b01: return 8;
            2'b10: return 4;
            2'b11: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic exp_ack(input logic [7:0] b);
        case (m_st)
            0: return (b[7:1] == {6'b011100, addr_sel_i}) && !b[0];
            1: return 1'b1;
            2: return m_sub == hw_subaddr_i;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string ack_tag();
        case (m_st)
            1: return "R2";
            2: return "R9";
            default: return "R1";
        endcase
    endfunction

    // Apply one accepted byte to the model (R1..R10 behaviour).
    task automatic model_byte(input logic [7:0] b);
        int nx;
        m_dv = 1'b0;
        case (m_st)
            0: begin
                m_tag = "R1";
                m_st = ((b[7:1] == {6'b011100, addr_sel_i}) && !b[0]) ? 1 : 3;
            end
            1: begin
                if (b[6:5] == 2'b10) begin
                    m_cfg[8:5] = b[3:0]; m_tag = "R3";
                end else if (b[6:5] == 2'b00) begin
                    m_ptr = b[4:0]; m_tag = "R4";
                end else if (b[6:3] == 4'b1100) begin
                    m_sub = b[2:0]; m_tag = "R5";
                end else if (b[6:2] == 5'b11110) begin
                    m_cfg[4:3] = b[1:0]; m_tag = "R6";
                end else if (b[6:3] == 4'b1110) begin
                    m_cfg[2:0] = b[2:0]; m_tag = "R7";
                end else begin
                    m_tag = "R8";
                end
                m_st = b[7] ? 1 : 2;
            end
            2: begin
                m_tag = "R10";
                if (m_sub == hw_subaddr_i) begin
                    m_dv = 1'b1; m_data = b; m_col = m_ptr;
                end
                nx = int'(m_ptr) + step_of(m_cfg[6:5]);
                if (nx >= 32) begin
                    nx -= 32;
                    m_sub = m_sub + 3'd1;
                end
                m_ptr = 5'(nx);
            end
            default: m_tag = "R1";
        endcase
    endtask

    task automatic chk_state(input string tag);
        chk(tag, {23'd0, disp_en_o, bias_half_o, mode_o, in_bank_o, out_bank_o,
                  blink_alt_o, blink_freq_o}, {23'd0, m_cfg});
        chk(tag, {27'd0, data_ptr_o}, {27'd0, m_ptr});
        chk(tag, {29'd0, subaddr_o}, {29'd0, m_sub});
        chk("R9", {31'd0, data_valid_o}, {31'd0, m_dv});
        if (m_dv) begin
            chk("R9", {24'd0, data_o}, {24'd0, m_data});
            chk("R9", {27'd0, wr_col_o}, {27'd0, m_col});
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_i = b; byte_valid_i = 1'b1;
        #1;
        chk(ack_tag(), {31'd0, ack_o}, {31'd0, exp_ack(b)});
        @(posedge clk);
        model_byte(b);
        @(negedge clk);
        byte_valid_i = 1'b0;
        chk_state(m_tag);
    endtask

    task automatic bus_cond(input logic is_start);
        @(negedge clk);
        start_i = is_start; stop_i = !is_start;
        @(posedge clk);
        m_st = 0; m_dv = 1'b0;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        chk_state("R12");
    endtask

    // START and byte strobe together: byte dropped, no acknowledge (R12).
    task automatic collide(input logic [7:0] b);
        @(negedge clk);
        start_i = 1'b1; byte_valid_i = 1'b1; byte_i = b;
        #1;
        chk("R12", {31'd0, ack_o}, 32'd0);
        @(posedge clk);
        m_st = 0; m_dv = 1'b0;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b0;
        chk_state("R12");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] addr;
        void'($urandom(32'h5eed_1cd0));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset values at the ports
        chk_state("R11");

        // Static mode, wrap at column 30 with subaddress step (R10, R9)
        bus_cond(1'b1);
        send_byte(8'h70);
        send_byte(8'hC9);   // mode-set: enable, one-third, static (R3)
        send_byte(8'h9E);   // pointer 30 (R4)
        send_byte(8'hE0);   // subaddress 0 (R5)
        send_byte(8'h7A);   // banks in=1 out=0, last command (R6)
        send_byte(8'hA5);   // written at 30, wrap to 6, sub 1
        send_byte(8'h3C);   // not acknowledged, sub 1 /= 0
        bus_cond(1'b0);

        // Three-way mode wrap and blink fields (R7, R10)
        bus_cond(1'b1);
        send_byte(8'h70);
        send_byte(8'hCB);
        send_byte(8'h9E);
        send_byte(8'hE0);
        send_byte(8'h76);
        send_byte(8'h11);
        send_byte(8'h22);
        bus_cond(1'b0);

        // Read request and wrong address are ignored (R1)
        bus_cond(1'b1);
        send_byte(8'h71);
        send_byte(8'h48);
        bus_cond(1'b1);
        addr_sel_i = 1'b1;
        send_byte(8'h70);
        send_byte(8'hC0);
        bus_cond(1'b1);
        send_byte(8'h72);
        // Unknown opcode acked, continuation honoured (R8)
        send_byte(8'hA0);
        send_byte(8'h48);
        send_byte(8'h5A);
        // STOP mid data, then a byte is parsed as address (R12)
        bus_cond(1'b0);
        send_byte(8'h00);
        collide(8'h72);
        send_byte(8'h72);
        send_byte(8'h80);
        send_byte(8'h1F);
        bus_cond(1'b0);

        // Constrained random transfers
        for (int t = 0; t < 300; t++) begin
            addr_sel_i = 1'($urandom % 2);
            hw_subaddr_i = 3'($urandom % 2);
            addr = {6'b011100, addr_sel_i, 1'b0};
            if ($urandom % 8 == 0) addr = 8'($urandom);
            if ($urandom % 20 == 0) collide(addr);
            else bus_cond(1'b1);
            send_byte(addr);
            begin
                int nc = 1 + int'($urandom % 4);
                for (int c = 0; c < nc; c++) begin
                    logic [7:0] u = 8'($urandom);
                    logic       cb = (c != nc - 1);
                    logic [7:0] b;
                    case ($urandom % 6)
                        0: b = {cb, 2'b10, u[4:0]};
                        1: b = {cb, 2'b00, u[4:0]};
                        2: b = {cb, 4'b1100, (u[7] ? hw_subaddr_i : u[2:0])};
                        3: b = {cb, 5'b11110, u[1:0]};
                        4: b = {cb, 4'b1110, u[2:0]};
                        default: b = {cb, u[6:0]};
                    endcase
                    send_byte(b);
                end
            end
            for (int d = 0; d < int'($urandom % 7); d++) send_byte(8'($urandom));
            bus_cond(1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule